// File: doc/BRIEF.md
# Line-Mappable Four-Target SPI Master

This block is an SPI master that serves up to four external targets over a 24-line general-purpose I/O field. Each target owns a small routing record that names which of the 24 lines carries its serial clock, its serial input (data arriving from the target), its serial output (data sent to the target) and its chip select. Lines 0 to 11 form the first bank and lines 12 to 23 the second. Bit i of every 24-bit vector at the ports belongs to line i. A line index of 24 or more never matches a line, so that signal is left unmapped.

Software loads the routing records through a simple write port. It then issues one command at a time. A command names the target, a clock divider, the edge on which serial input is sampled, a data word and a bit count. The engine runs a full-duplex shift and drives only the active target's clock, output and select lines. It captures the target's reply, raises a one-cycle completion pulse and holds the captured word. The direction register of the GPIO field lies outside this block, which only asks for drive through its output-enable vector.

Top module: `spi_pinmux_master`

## Requirements
- R1: After reset, busy, done, rdData and every bit of gpioOe are 0.
- R2: cfgWe with cfgIdx writes the four line indices of one of four routing records. A command for target p drives gpioOe high on exactly that record's clock, select and serial-output lines, and never on its serial-input line.
- R3: With d = max(cmdDiv,1), one SCLK period is P = d+1 clock cycles. The high phase lasts H = floor(P/2) cycles and the low phase L = P-H cycles. SCLK is low whenever the engine is idle.
- R4: The serial output sends the low n bits of cmdData most significant bit first, one bit per SCLK period. It changes only after a falling SCLK edge and holds while SCLK is high.
- R5: cmdSdiFall=0 samples the serial-input line on each rising SCLK edge and cmdSdiFall=1 on each falling edge. rdData holds the n sampled bits right-justified, first bit in bit n-1, with the upper bits zero.
- R6: cmdBits gives n from 1 to 32. A value of 0 or above 32 means 32.
- R7: Chip select is active low. It falls L cycles before the first rising SCLK edge and rises L cycles after the last falling edge.
- R8: Before the first command, gpioOe is all zero. Between commands the last target's lines stay driven, with select high and SCLK low. Lines of other targets, unmapped lines and the serial-input line keep gpioOe low.
- R9: busy rises on the cycle after a command is accepted (cmdValid while not busy) and stays high for n*P+L cycles. cmdValid while busy is ignored.
- R10: done pulses for exactly one cycle, in the first cycle busy is low again. rdData changes only at that point and holds until the next completion.
- R11: A routing-record write made while a transaction runs does not alter that transaction's line usage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Routing record write strobe |
| cfgIdx | input | 2 | Target whose record is written |
| cfgSclkLine | input | 5 | Line index for SCLK |
| cfgSdiLine | input | 5 | Line index for serial input |
| cfgSdoLine | input | 5 | Line index for serial output |
| cfgCsLine | input | 5 | Line index for chip select |
| cmdValid | input | 1 | Command request |
| cmdPeriph | input | 2 | Target index of the command |
| cmdDiv | input | 8 | Clock divider |
| cmdSdiFall | input | 1 | 1: sample serial input on falling edge |
| cmdBits | input | 6 | Bit count (0 or >32 means 32) |
| cmdData | input | 32 | Write word, low n bits sent |
| gpioIn | input | 24 | Line input values |
| gpioOut | output | 24 | Line output values |
| gpioOe | output | 24 | Line output enables |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Captured serial-input word |

## Verification
The embedded properties check the following on every cycle: the completion pulse's width and its alignment with busy falling, the freezing of timing parameters against commands issued while busy, the serial output holding through each SCLK high phase, and rdData holding between completions. Line routing, edge timing in cycles, bit order, input sampling edge and bit-count normalisation can only be shown by the bench. It sweeps every target, several dividers, both sampling edges and a range of bit counts, and checks each line against a model of an attached target.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int NUM_LINES  = 24;
  localparam int LINE_W     = 5;
  localparam int NUM_PERIPH = 4;
  localparam int PIDX_W     = 2;
  localparam int MAX_BITS   = 32;
  localparam int CNT_W      = 6;

  typedef struct packed {
    logic [LINE_W-1:0] sclk;
    logic [LINE_W-1:0] sdi;
    logic [LINE_W-1:0] sdo;
    logic [LINE_W-1:0] cs;
  } lineMap_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sampleNow;
    logic shiftNow;
    logic finish;
    logic sclk;
    logic csN;
  } spmStrb_t;
endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [DIV_W-1:0] cmdDiv,
  input  logic             cmdSdiFall,
  input  logic [CNT_W-1:0] cmdBits,
  output logic [CNT_W-1:0] nBitsEff,
  output spmStrb_t         strb,
  output logic             busy,
  output logic             done
);
  localparam int LEN_W = DIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_TAIL} state_t;

  state_t            state;
  logic [LEN_W-1:0]  loLen, hiLen, cnt;
  logic [CNT_W-1:0]  bitsLeft;
  logic              fallSel;

  logic [DIV_W-1:0]  divEff;
  logic [LEN_W-1:0]  perEff, hiNext, loNext;
  logic              accept, loEnd, hiEnd;

  always_comb begin
    divEff   = (cmdDiv == '0) ? DIV_W'(1) : cmdDiv;
    perEff   = {1'b0, divEff} + LEN_W'(1);
    hiNext   = perEff >> 1;
    loNext   = perEff - hiNext;
    nBitsEff = (cmdBits == '0 || cmdBits > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : cmdBits;
    accept   = cmdValid && (state == S_IDLE);
    loEnd    = (cnt == loLen - LEN_W'(1));
    hiEnd    = (cnt == hiLen - LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      loLen    <= LEN_W'(1);
      hiLen    <= LEN_W'(1);
      cnt      <= '0;
      bitsLeft <= '0;
      fallSel  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          state    <= S_LOW;
          cnt      <= '0;
          loLen    <= loNext;
          hiLen    <= hiNext;
          fallSel  <= cmdSdiFall;
          bitsLeft <= nBitsEff - CNT_W'(1);
        end
        S_LOW: begin
          if (loEnd) begin
            state <= S_HIGH;
            cnt   <= '0;
          end else cnt <= cnt + LEN_W'(1);
        end
        S_HIGH: begin
          if (hiEnd) begin
            cnt <= '0;
            if (bitsLeft == '0) state <= S_TAIL;
            else begin
              state    <= S_LOW;
              bitsLeft <= bitsLeft - CNT_W'(1);
            end
          end else cnt <= cnt + LEN_W'(1);
        end
        S_TAIL: begin
          if (loEnd) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt + LEN_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load      = accept;
    strb.sampleNow = (state == S_LOW  && loEnd && !fallSel) ||
                     (state == S_HIGH && hiEnd &&  fallSel);
    strb.shiftNow  = (state == S_HIGH) && hiEnd && (bitsLeft != '0);
    strb.finish    = (state == S_TAIL) && loEnd;
    strb.sclk      = (state == S_HIGH);
    strb.csN       = (state == S_IDLE);
    busy           = (state != S_IDLE);
  end

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r9_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmdValid) |=> ($stable(loLen) && $stable(hiLen) && $stable(fallSel)));
  a_r6_bits_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitsLeft < CNT_W'(MAX_BITS)));
endmodule

// File: rtl/spm_datapath.sv
module spm_datapath
  import spm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  spmStrb_t             strb,
  input  logic                 cfgWe,
  input  logic [PIDX_W-1:0]    cfgIdx,
  input  lineMap_t             cfgMap,
  input  logic [PIDX_W-1:0]    cmdPeriph,
  input  logic [MAX_BITS-1:0]  cmdData,
  input  logic [CNT_W-1:0]     nBits,
  input  logic [NUM_LINES-1:0] gpioIn,
  output logic [NUM_LINES-1:0] gpioOut,
  output logic [NUM_LINES-1:0] gpioOe,
  output logic [MAX_BITS-1:0]  rdData
);
  lineMap_t             mapTbl [NUM_PERIPH];
  lineMap_t             act;
  logic                 owned;
  logic [MAX_BITS-1:0]  txSh, rxSh;
  logic                 sdiBit, sdoBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PERIPH; p++) mapTbl[p] <= '1;
    end else if (cfgWe) begin
      mapTbl[cfgIdx] <= cfgMap;
    end
  end

  always_comb begin
    sdiBit = (act.sdi < LINE_W'(NUM_LINES)) ? gpioIn[act.sdi] : 1'b0;
    sdoBit = txSh[MAX_BITS-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= '1;
      owned  <= 1'b0;
      txSh   <= '0;
      rxSh   <= '0;
      rdData <= '0;
    end else begin
      if (strb.load) begin
        act   <= mapTbl[cmdPeriph];
        owned <= 1'b1;
        txSh  <= cmdData << (CNT_W'(MAX_BITS) - nBits);
        rxSh  <= '0;
      end else begin
        if (strb.shiftNow)  txSh <= txSh << 1;
        if (strb.sampleNow) rxSh <= {rxSh[MAX_BITS-2:0], sdiBit};
      end
      if (strb.finish) rdData <= rxSh;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic isClk, isSdi, isSdo, isCs;
    always_comb begin
      isClk = (act.sclk == LINE_W'(i));
      isSdi = (act.sdi  == LINE_W'(i));
      isSdo = (act.sdo  == LINE_W'(i));
      isCs  = (act.cs   == LINE_W'(i));
      gpioOe[i]  = owned && (isClk || isSdo || isCs) && !isSdi;
      gpioOut[i] = isCs ? strb.csN : isSdo ? sdoBit : isClk ? strb.sclk : 1'b0;
    end
  end

  a_r4_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.sclk && $past(strb.sclk)) |-> (sdoBit == $past(sdoBit)));
  a_r10_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strb.finish) |-> $stable(rdData));
endmodule

// File: rtl/spi_pinmux_master.sv
module spi_pinmux_master
  import spm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWe,
  input  logic [PIDX_W-1:0]    cfgIdx,
  input  logic [LINE_W-1:0]    cfgSclkLine,
  input  logic [LINE_W-1:0]    cfgSdiLine,
  input  logic [LINE_W-1:0]    cfgSdoLine,
  input  logic [LINE_W-1:0]    cfgCsLine,
  input  logic                 cmdValid,
  input  logic [PIDX_W-1:0]    cmdPeriph,
  input  logic [DIV_W-1:0]     cmdDiv,
  input  logic                 cmdSdiFall,
  input  logic [CNT_W-1:0]     cmdBits,
  input  logic [MAX_BITS-1:0]  cmdData,
  input  logic [NUM_LINES-1:0] gpioIn,
  output logic [NUM_LINES-1:0] gpioOut,
  output logic [NUM_LINES-1:0] gpioOe,
  output logic                 busy,
  output logic                 done,
  output logic [MAX_BITS-1:0]  rdData
);
  spmStrb_t         strb;
  logic [CNT_W-1:0] nBitsEff;
  lineMap_t         cfgMap;

  always_comb begin
    cfgMap.sclk = cfgSclkLine;
    cfgMap.sdi  = cfgSdiLine;
    cfgMap.sdo  = cfgSdoLine;
    cfgMap.cs   = cfgCsLine;
  end

  spm_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdDiv(cmdDiv),
    .cmdSdiFall(cmdSdiFall), .cmdBits(cmdBits), .nBitsEff(nBitsEff),
    .strb(strb), .busy(busy), .done(done)
  );

  spm_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgMap(cfgMap), .cmdPeriph(cmdPeriph), .cmdData(cmdData), .nBits(nBitsEff),
    .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .rdData(rdData)
  );
endmodule

// File: tb/test_spi_pinmux_master.sv
`timescale 1ns/1ps
module test_spi_pinmux_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfgWe;
  logic [1:0]  cfgIdx;
  logic [4:0]  cfgSclkLine, cfgSdiLine, cfgSdoLine, cfgCsLine;
  logic        cmdValid;
  logic [1:0]  cmdPeriph;
  logic [7:0]  cmdDiv;
  logic        cmdSdiFall;
  logic [5:0]  cmdBits;
  logic [31:0] cmdData;
  logic [23:0] gpioIn;
  logic [23:0] gpioOut, gpioOe;
  logic        busy, done;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;

  int mSclk [4] = '{0, 12, 23, 7};
  int mSdi  [4] = '{1, 13, 5, 20};
  int mSdo  [4] = '{2, 14, 11, 9};
  int mCs   [4] = '{3, 15, 18, 4};

  always #2 clk = ~clk;

  spi_pinmux_master i_spi_pinmux_master (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgSclkLine(cfgSclkLine), .cfgSdiLine(cfgSdiLine), .cfgSdoLine(cfgSdoLine),
    .cfgCsLine(cfgCsLine), .cmdValid(cmdValid), .cmdPeriph(cmdPeriph),
    .cmdDiv(cmdDiv), .cmdSdiFall(cmdSdiFall), .cmdBits(cmdBits), .cmdData(cmdData),
    .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .busy(busy),
    .done(done), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeMap(input int p, input int s, input int i, input int o, input int c);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 2'(p);
    cfgSclkLine = 5'(s); cfgSdiLine = 5'(i); cfgSdoLine = 5'(o); cfgCsLine = 5'(c);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [23:0] maskOf(input int p);
    return (24'(1) << mSclk[p]) | (24'(1) << mSdo[p]) | (24'(1) << mCs[p]);
  endfunction

  // One transaction with a modelled target; optional injection of a rejected
  // command (R9) and a mid-transaction map rewrite (R11).
  task automatic runTxn(input int p, input int dv, input bit fall,
                        input logic [31:0] data, input logic [31:0] resp,
                        input int nb, input bit inject, input bit remap);
    int n, per, hi, lo, c, ptr, rises, rowErr, oeErr, csErr, sdoErr, bsyErr, doneAt;
    int firstRise, lastFall;
    bit prevClk, sc;
    logic [31:0] got, expTx, expRx;
    n   = (nb == 0 || nb > 32) ? 32 : nb;
    per = ((dv == 0) ? 1 : dv) + 1;
    hi  = per / 2;
    lo  = per - hi;
    expTx = (n == 32) ? data : (data & ((32'd1 << n) - 1));
    expRx = (n == 32) ? resp : (resp & ((32'd1 << n) - 1));
    ptr = fall ? n : n - 1;
    @(negedge clk);
    cmdValid = 1'b1; cmdPeriph = 2'(p); cmdDiv = 8'(dv);
    cmdSdiFall = fall; cmdBits = 6'(nb); cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
    c = 1; rises = 0; rowErr = 0; oeErr = 0; csErr = 0; sdoErr = 0; bsyErr = 0;
    doneAt = -1; firstRise = -1; lastFall = -1; prevClk = 1'b0; got = '0;
    while (c < 3000) begin
      sc = gpioOut[mSclk[p]];
      if (done) begin doneAt = c; break; end
      if (!busy) bsyErr++;
      if (gpioOe !== maskOf(p)) oeErr++;
      if (gpioOut[mCs[p]] !== 1'b0) csErr++;
      if (sc && !prevClk) begin
        if (firstRise < 0) firstRise = c;
        else if (c != firstRise + rises * per) rowErr++;
        rises++;
        got = {got[30:0], gpioOut[mSdo[p]]};
        if (fall) ptr--;
      end
      if (sc && prevClk && gpioOut[mSdo[p]] !== got[0]) sdoErr++;
      if (!sc && prevClk) begin
        lastFall = c;
        if (c != firstRise + (rises - 1) * per + hi) rowErr++;
        if (!fall) ptr--;
      end
      prevClk = sc;
      gpioIn = 24'hA5A5A5;
      gpioIn[mSdi[p]] = (ptr >= 0 && ptr < 32) ? resp[ptr] : 1'b0;
      if (inject && c == 2) begin
        cmdValid = 1'b1; cmdPeriph = 2'((p + 1) % 4); cmdDiv = 8'd9;
        cmdBits = 6'd3; cmdData = ~data; cmdSdiFall = ~fall;
      end else cmdValid = 1'b0;
      if (remap && c == 3) begin
        cfgWe = 1'b1; cfgIdx = 2'(p);
        cfgSclkLine = 5'd21; cfgSdiLine = 5'd22; cfgSdoLine = 5'd17; cfgCsLine = 5'd16;
      end else cfgWe = 1'b0;
      @(negedge clk);
      c++;
    end
    chk(doneAt == n * per + lo + 1, "R9", "busy length", doneAt, n * per + lo + 1);
    chk(bsyErr == 0, "R9", "busy held during txn", bsyErr, 0);
    chk(rises == n, "R6", "SCLK rising edges", rises, n);
    chk(firstRise == lo + 1, "R7", "CS lead to first rise", firstRise, lo + 1);
    chk(doneAt - lastFall == lo, "R7", "CS trail after last fall", doneAt - lastFall, lo);
    chk(rowErr == 0, "R3", "SCLK phase timing errors", rowErr, 0);
    chk(csErr == 0, "R7", "CS low through txn", csErr, 0);
    chk(oeErr == 0, remap ? "R11" : "R2", "output-enable mask", oeErr, 0);
    chk(got == expTx && sdoErr == 0, "R4", "SDO bits", got, expTx);
    chk(rdData == expRx, fall ? "R5 fall" : "R5 rise", "rdData", rdData, expRx);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
    chk(gpioOe == maskOf(p) && gpioOut[mCs[p]] == 1'b1 && gpioOut[mSclk[p]] == 1'b0,
        "R8", "idle drive", gpioOe, maskOf(p));
    chk(rdData == expRx, "R10", "rdData held", rdData, expRx);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int divs [5] = '{0, 1, 2, 3, 6};
    int nbs  [5] = '{1, 5, 32, 0, 45};
    int k = 0;
    rst_n = 1'b0; cfgWe = 1'b0; cfgIdx = '0; cfgSclkLine = '0; cfgSdiLine = '0;
    cfgSdoLine = '0; cfgCsLine = '0; cmdValid = 1'b0; cmdPeriph = '0; cmdDiv = '0;
    cmdSdiFall = 1'b0; cmdBits = '0; cmdData = '0; gpioIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && rdData == 0 && gpioOe == 0, "R1", "reset state",
        {busy, done, gpioOe}, 0);
    for (int p = 0; p < 4; p++) writeMap(p, mSclk[p], mSdi[p], mSdo[p], mCs[p]);
    chk(gpioOe == 0, "R8", "no drive before first command", gpioOe, 0);

    for (int p = 0; p < 4; p++)
      for (int d = 0; d < 5; d++)
        for (int f = 0; f < 2; f++)
          for (int b = 0; b < 5; b++) begin
            k++;
            runTxn(p, divs[d], f[0], 32'h9E3779B9 * k, 32'h7F4A7C15 ^ (k * 32'h01000193),
                   nbs[b], (k % 7) == 0, 1'b0);
          end

    // R11: rewrite record 2 during its transaction, then restore it
    runTxn(2, 3, 1'b0, 32'hCAFE1234, 32'h0BADF00D, 16, 1'b1, 1'b1);
    writeMap(2, mSclk[2], mSdi[2], mSdo[2], mCs[2]);
    runTxn(2, 2, 1'b1, 32'h13572468, 32'h2468ACE0, 12, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule